// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns one 32-bit memory-reference instruction word into the word address that the following memory access will use. It splits the word into an indirect flag, a 7-bit operation code, a 4-bit register selector, a 3-bit index selector and a 17-bit reference field. It can fetch one pointer word from memory and take its address bits in place of the reference field. It then adds the content of an index register, unless the index selector is zero.

Two address modes are supported, and both are sampled when an operation starts. In the plain mode the result is 17 bits wide, so it reaches 128K words. In the extended mode, the top bit of the reference field chooses where the low 16 bits point. When that bit is clear, they address the lowest 64K words. When it is set, a 6-bit extension value, taken from the status register, is placed above the low 16 bits to give a 22-bit physical word address.

The surrounding pipeline pulses `start` while the unit is idle. It then waits for `done` and takes the address, operation code and register selector. It confirms with `ack`, and the unit returns to idle.

Top module: `eaddr_unit`

## Requirements
- R1: When `done` rises, `opcode` equals instruction bits [30:24] and `rfield` equals bits [23:20] of the instruction sampled at `start`.
- R2: In plain mode (`ext_mode`=0) with bit 31 clear and index selector [19:17] equal to 0, `done` is high one cycle after `start` and `ea` equals bits [16:0] zero-extended to 22 bits.
- R3: With index selector s in 1..7, `xsel` presents s and, in plain mode, `ea` equals (reference + `xdata`) modulo 2^17, with bits [21:17] zero.
- R4: An index selector of 0 adds nothing: the value on `xdata` has no effect on `ea`.
- R5: In extended mode with reference bit 16 clear, `ea` equals {6'b0, reference[15:0]} plus the selected index value, modulo 2^22.
- R6: In extended mode with reference bit 16 set, `ea` equals {`ext_base`, reference[15:0]} plus the selected index value, modulo 2^22, using `ext_base` as sampled at `start`.
- R7: With instruction bit 31 set, the unit raises `mem_req` with `mem_addr` set to the mapped, unindexed reference, and holds both until `mem_ack`. After `mem_rvalid`, it uses `mem_rdata[16:0]` as the reference under the same mode. It then applies the original index selector. Bits 31 and [19:17] of the fetched word are ignored, so there is only one level of indirection.
- R8: `done`, `ea`, `opcode` and `rfield` hold steady until `ack` is sampled high, after which `done` falls. A `start` pulse while `done` is high is ignored.
- R9: The index addition wraps without any flag: in plain mode at 2^17, in extended mode at 2^22.
- R10: After synchronous reset, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| inst | input | 32 | Memory-reference instruction word |
| ext_mode | input | 1 | Extended addressing mode select |
| ext_base | input | 6 | Extension value from the status register |
| xsel | output | 3 | Index register read select |
| xdata | input | 32 | Index register content for `xsel` |
| mem_req | output | 1 | Pointer word read request |
| mem_addr | output | 22 | Pointer word address |
| mem_ack | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Pointer word read data |
| done | output | 1 | Result valid |
| ack | input | 1 | Result consumed |
| ea | output | 22 | Effective word address |
| opcode | output | 7 | Operation code field |
| rfield | output | 4 | Register selector field |

## Verification
If the controller is in the wrong state, the handshakes show it within a cycle. `done` comes up before the pointer read completes, `mem_req` drops before it is acknowledged, or `done` never falls after `ack`. If the captured mode, extension value or index selector is wrong, the error only appears in `ea`, and only for the combinations it affects. For that reason the bench sweeps all eight index selectors across both modes, both settings of the extension select bit, both direct and indirect access, and operands chosen to make the sums wrap. While an operation is in progress, the bench drives different values onto the instruction and mode inputs, so any late sampling of those inputs changes the result.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int INST_W = 32;
    localparam int OPC_W  = 7;
    localparam int RSEL_W = 4;
    localparam int IDX_W  = 3;
    localparam int REF_W  = 17;
    localparam int LOW_W  = 16;

    // Instruction layout, most significant field first
    typedef struct packed {
        logic               ind;
        logic [OPC_W-1:0]   opc;
        logic [RSEL_W-1:0]  rsel;
        logic [IDX_W-1:0]   idx;
        logic [REF_W-1:0]   refa;
    } inst_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_IND_REQ  = 2'd1,
        ST_IND_WAIT = 2'd2,
        ST_DONE     = 2'd3
    } eag_state_e;

    function automatic inst_t unpack_inst(input logic [INST_W-1:0] w);
        return inst_t'(w);
    endfunction

    function automatic logic index_enabled(input logic [IDX_W-1:0] s);
        return s != '0;
    endfunction

endpackage

// File: rtl/eag_decode.sv
module eag_decode
    import eag_pkg::*;
(
    input  logic [INST_W-1:0] word,
    output inst_t             fields
);
    always_comb begin
        fields = unpack_inst(word);
    end
endmodule

// File: rtl/eag_addr_form.sv
module eag_addr_form
    import eag_pkg::*;
#(
    parameter int EXT_W   = 6,
    parameter int XDATA_W = 32,
    localparam int PA_W   = LOW_W + EXT_W
)(
    input  logic [REF_W-1:0]   refa,
    input  logic               ext_mode,
    input  logic [EXT_W-1:0]   ext_val,
    input  logic               use_idx,
    input  logic [XDATA_W-1:0] xdata,
    output logic [PA_W-1:0]    pa
);
    logic [PA_W-1:0]  xv_full;
    logic [PA_W-1:0]  xv;
    logic [PA_W-1:0]  base_ext;
    logic [PA_W-1:0]  sum_ext;
    logic [REF_W-1:0] sum_nrm;

    generate
        if (XDATA_W >= PA_W) begin : g_trunc
            assign xv_full = xdata[PA_W-1:0];
            if (XDATA_W > PA_W) begin : g_hi
                logic unused_xhi;
                assign unused_xhi = ^xdata[XDATA_W-1:PA_W];
            end
        end else begin : g_zext
            assign xv_full = {{(PA_W-XDATA_W){1'b0}}, xdata};
        end
    endgenerate

    always_comb begin
        xv = use_idx ? xv_full : '0;
        if (refa[REF_W-1])
            base_ext = {ext_val, refa[LOW_W-1:0]};
        else
            base_ext = {{EXT_W{1'b0}}, refa[LOW_W-1:0]};
        sum_ext = base_ext + xv;
        sum_nrm = refa + xv[REF_W-1:0];
        pa = ext_mode ? sum_ext : {{(PA_W-REF_W){1'b0}}, sum_nrm};
    end
endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
    import eag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       is_ind,
    input  logic       mem_ack,
    input  logic       mem_rvalid,
    input  logic       ack,
    output eag_state_e state
);
    eag_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start)      nxt = is_ind ? ST_IND_REQ : ST_DONE;
            ST_IND_REQ:  if (mem_ack)    nxt = ST_IND_WAIT;
            ST_IND_WAIT: if (mem_rvalid) nxt = ST_DONE;
            ST_DONE:     if (ack)        nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R7
    wait_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IND_WAIT) |-> ($past(state) == ST_IND_REQ || $past(state) == ST_IND_WAIT));

    // R8
    done_exit_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_DONE && state == ST_IDLE) |-> $past(ack));
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit
    import eag_pkg::*;
#(
    parameter int EXT_W   = 6,
    parameter int XDATA_W = 32,
    localparam int PA_W   = LOW_W + EXT_W
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [INST_W-1:0]   inst,
    input  logic                ext_mode,
    input  logic [EXT_W-1:0]    ext_base,
    output logic [IDX_W-1:0]    xsel,
    input  logic [XDATA_W-1:0]  xdata,
    output logic                mem_req,
    output logic [PA_W-1:0]     mem_addr,
    input  logic                mem_ack,
    input  logic                mem_rvalid,
    input  logic [INST_W-1:0]   mem_rdata,
    output logic                done,
    input  logic                ack,
    output logic [PA_W-1:0]     ea,
    output logic [OPC_W-1:0]    opcode,
    output logic [RSEL_W-1:0]   rfield
);
    eag_state_e         st;
    inst_t              in_f;
    inst_t              q_f;
    logic               mode_q;
    logic [EXT_W-1:0]   ext_q;
    logic [PA_W-1:0]    ptr_q;
    logic [PA_W-1:0]    ea_q;
    logic [OPC_W-1:0]   opc_q;
    logic [RSEL_W-1:0]  rs_q;

    logic               idle;
    logic               accept;
    logic               fin_load;
    logic [REF_W-1:0]   fin_ref;
    logic               fin_mode;
    logic [EXT_W-1:0]   fin_ext;
    logic [IDX_W-1:0]   cur_idx;
    logic [PA_W-1:0]    ptr_pa;
    logic [PA_W-1:0]    fin_pa;
    logic [XDATA_W-1:0] zero_x;

    logic unused_bits;
    assign unused_bits = q_f.ind ^ (^q_f.refa) ^ (^mem_rdata[INST_W-1:REF_W]);

    eag_decode u_dec (
        .word   (inst),
        .fields (in_f)
    );

    eag_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .is_ind     (in_f.ind),
        .mem_ack    (mem_ack),
        .mem_rvalid (mem_rvalid),
        .ack        (ack),
        .state      (st)
    );

    assign idle     = (st == ST_IDLE);
    assign accept   = idle && start;
    assign fin_load = (accept && !in_f.ind) || (st == ST_IND_WAIT && mem_rvalid);
    assign zero_x   = '0;

    always_comb begin
        fin_ref  = idle ? in_f.refa : mem_rdata[REF_W-1:0];
        fin_mode = idle ? ext_mode  : mode_q;
        fin_ext  = idle ? ext_base  : ext_q;
        cur_idx  = idle ? in_f.idx  : q_f.idx;
    end

    assign xsel = cur_idx;

    // Pointer address: mapped reference, never indexed
    eag_addr_form #(.EXT_W(EXT_W), .XDATA_W(XDATA_W)) u_ptr (
        .refa     (in_f.refa),
        .ext_mode (ext_mode),
        .ext_val  (ext_base),
        .use_idx  (1'b0),
        .xdata    (zero_x),
        .pa       (ptr_pa)
    );

    // Final address: mapped reference plus selected index
    eag_addr_form #(.EXT_W(EXT_W), .XDATA_W(XDATA_W)) u_fin (
        .refa     (fin_ref),
        .ext_mode (fin_mode),
        .ext_val  (fin_ext),
        .use_idx  (index_enabled(cur_idx)),
        .xdata    (xdata),
        .pa       (fin_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q_f    <= '0;
            mode_q <= 1'b0;
            ext_q  <= '0;
            ptr_q  <= '0;
            ea_q   <= '0;
            opc_q  <= '0;
            rs_q   <= '0;
        end else begin
            if (accept) begin
                q_f    <= in_f;
                mode_q <= ext_mode;
                ext_q  <= ext_base;
                ptr_q  <= ptr_pa;
            end
            if (fin_load) begin
                ea_q  <= fin_pa;
                opc_q <= idle ? in_f.opc  : q_f.opc;
                rs_q  <= idle ? in_f.rsel : q_f.rsel;
            end
        end
    end

    assign mem_req  = (st == ST_IND_REQ);
    assign mem_addr = ptr_q;
    assign done     = (st == ST_DONE);
    assign ea       = ea_q;
    assign opcode   = opc_q;
    assign rfield   = rs_q;

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !ack) |=> (done && $stable(ea) && $stable(opcode) && $stable(rfield)));

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ack) |=> !done);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R7
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !done);

    // R3
    plain_width_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> (ea[PA_W-1:REF_W] == '0));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!done && !mem_req));
endmodule

// File: tb/tb_eaddr_unit.sv
module tb_eaddr_unit;
    localparam int PA_W = 22;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] inst;
    logic        ext_mode;
    logic [5:0]  ext_base;
    logic [2:0]  xsel;
    logic [31:0] xdata;
    logic        mem_req;
    logic [21:0] mem_addr;
    logic        mem_ack;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done;
    logic        ack;
    logic [21:0] ea;
    logic [6:0]  opcode;
    logic [3:0]  rfield;

    logic [31:0] xr [8];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign xdata = xr[xsel];

    eaddr_unit dut (
        .clk(clk), .rst(rst), .start(start), .inst(inst),
        .ext_mode(ext_mode), .ext_base(ext_base), .xsel(xsel), .xdata(xdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .ack(ack), .ea(ea), .opcode(opcode), .rfield(rfield)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [21:0] map_ref(input logic [16:0] r, input bit m,
                                            input logic [5:0] e);
        if (!m) return {5'd0, r};
        return r[16] ? {e, r[15:0]} : {6'd0, r[15:0]};
    endfunction

    function automatic logic [21:0] exp_ea(input logic [16:0] r, input bit m,
                                           input logic [5:0] e, input logic [2:0] s);
        logic [21:0] x;
        logic [16:0] n;
        x = (s == 3'd0) ? 22'd0 : xr[s][21:0];
        if (m) return map_ref(r, m, e) + x;
        n = r + x[16:0];
        return {5'd0, n};
    endfunction

    // Pointer word contents: indirect flag and index bits set to prove they are ignored
    function automatic logic [31:0] mem_word(input logic [21:0] a);
        logic [21:0] h;
        h = a * 22'd7 + 22'h0_2345;
        return {1'b1, 7'h55, 4'hA, 3'h7, h[16:0] ^ {a[21:17], 12'h0}};
    endfunction

    task automatic run_op(input bit ind, input logic [6:0] opc, input logic [3:0] rs,
                          input logic [2:0] s, input logic [16:0] r, input bit m,
                          input logic [5:0] e, input string tag);
        logic [31:0] w;
        logic [16:0] fref;
        logic [21:0] paddr;
        logic [21:0] held;
        w = {ind, opc, rs, s, r};
        @(negedge clk);
        start = 1'b1; inst = w; ext_mode = m; ext_base = e;
        @(negedge clk);
        start = 1'b0; inst = ~w; ext_mode = ~m; ext_base = ~e;
        if (ind) begin
            paddr = map_ref(r, m, e);
            chk("R7", "mem_req raised", {31'd0, mem_req}, 32'd1);
            chk("R7", "pointer address", {10'd0, mem_addr}, {10'd0, paddr});
            chk("R7", "done low during fetch", {31'd0, done}, 32'd0);
            @(negedge clk);
            chk("R7", "mem_req held", {31'd0, mem_req}, 32'd1);
            chk("R7", "address held", {10'd0, mem_addr}, {10'd0, paddr});
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            chk("R7", "mem_req dropped after accept", {31'd0, mem_req}, 32'd0);
            chk("R7", "done low before data", {31'd0, done}, 32'd0);
            @(negedge clk);
            mem_rvalid = 1'b1; mem_rdata = mem_word(paddr);
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = 32'hFFFF_FFFF;
            fref = mem_word(paddr) >> 0;
        end else begin
            fref = r;
        end
        chk(tag, "done", {31'd0, done}, 32'd1);
        chk(tag, "ea", {10'd0, ea}, {10'd0, exp_ea(fref, m, e, s)});
        chk("R1", "opcode", {25'd0, opcode}, {25'd0, opc});
        chk("R1", "rfield", {28'd0, rfield}, {28'd0, rs});
        held = ea;
        start = 1'b1; inst = {1'b0, ~opc, ~rs, 3'd1, ~r};
        @(negedge clk);
        start = 1'b0;
        chk("R8", "done held without ack", {31'd0, done}, 32'd1);
        chk("R8", "ea held, start ignored", {10'd0, ea}, {10'd0, held});
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R8", "done falls after ack", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [16:0] refs [5];
        logic [5:0]  exts [5];
        int n;
        string tag;
        xr[0] = 32'hDEAD_BEEF; xr[1] = 32'h0000_0001; xr[2] = 32'h0001_FFFF;
        xr[3] = 32'h003F_FFFF; xr[4] = 32'hFFFF_FFFF; xr[5] = 32'h0000_1234;
        xr[6] = 32'h0020_0000; xr[7] = 32'h0000_0007;
        refs[0] = 17'h00000; refs[1] = 17'h1FFFF; refs[2] = 17'h0FFFF;
        refs[3] = 17'h10000; refs[4] = 17'h12345;
        exts[0] = 6'h00; exts[1] = 6'h3F; exts[2] = 6'h2A; exts[3] = 6'h15; exts[4] = 6'h01;

        rst = 1'b1; start = 1'b0; inst = '0; ext_mode = 1'b0; ext_base = '0;
        mem_ack = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0; ack = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10", "done after reset", {31'd0, done}, 32'd0);
        chk("R10", "mem_req after reset", {31'd0, mem_req}, 32'd0);
        rst = 1'b0;

        // Directed wrap cases
        run_op(1'b0, 7'h11, 4'h2, 3'd1, 17'h1FFFF, 1'b0, 6'h00, "R9");
        run_op(1'b0, 7'h12, 4'h3, 3'd1, 17'h1FFFF, 1'b1, 6'h3F, "R9");
        run_op(1'b0, 7'h13, 4'h4, 3'd4, 17'h00000, 1'b1, 6'h00, "R9");
        run_op(1'b0, 7'h14, 4'h5, 3'd0, 17'h0ABCD, 1'b0, 6'h00, "R2");

        // Sweep
        n = 0;
        for (int ind = 0; ind < 2; ind++) begin
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < 8; s++) begin
                    for (int k = 0; k < 5; k++) begin
                        if (ind != 0)       tag = "R7";
                        else if (m != 0)    tag = refs[k][16] ? "R6" : "R5";
                        else if (s == 0)    tag = "R4";
                        else                tag = "R3";
                        run_op(ind[0], 7'((n * 13) % 128), 4'(n % 16), 3'(s),
                               refs[k], m[0], exts[k], tag);
                        n++;
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule